// File: doc/BRIEF.md
# Multi-Mode Pixel Formatter with Bank Switching

This block sits between a video-memory fetch engine and the display timing logic. It takes 32-bit words from a valid/ready stream and turns them into a stream of 24-bit RGB pixels, one per handshake. The pixel format is picked by a two-bit mode input, captured with each word. The modes are true colour (one pixel per word), RGB565 (two per word), 8-bit gray-scale (four per word) and 8-bit indexed colour (four per word). In indexed mode each 8-bit value, offset by the active table base, goes out on a request port to an external colour table. The returned entry becomes the pixel.

The block also keeps two pairs of base registers: two video page bases and two colour table offsets. It shows the active member of each pair. When the matching enable is high on a vertical retrace strobe, that selection flips. The fetch engine can then alternate pages or palettes every frame with no host involvement.

Top module: `pixel_formatter`

## Requirements
- R1: While reset is held and after it is released, out_valid, lut_req, page_sel, table_sel and swap_done are 0 and in_ready is 1.
- R2: Mode 0 (true colour) yields one pixel per word, equal to in_data[23:0], with red in bits 23:16, green in 15:8 and blue in 7:0. Bits 31:24 are ignored.
- R3: Mode 1 (RGB565) yields two pixels per word, bits 15:0 first. Each 16-bit value holds red in 15:11, green in 10:5 and blue in 4:0. Each channel widens to 8 bits by repeating its top bits below its own bits.
- R4: Mode 2 (gray-scale) yields four pixels per word, bits 7:0 first. Each 8-bit value v becomes {v,v,v}.
- R5: Mode 3 (indexed) takes four 8-bit values per word, bits 7:0 first. For each one, lut_req rises with lut_idx = active table base + value (modulo 2^LW). Both hold steady until lut_ack. The lut_data sampled with lut_ack becomes the next pixel.
- R6: in_ready is 0 from the cycle after a word is accepted until the last pixel of that word has been handed on. Pixels leave in the order of their words and positions.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_rgb does not change.
- R8: A retrace strobe with page_swap_en high flips page_sel on that edge. page_base always shows page_base1 when page_sel is 1 and page_base0 otherwise.
- R9: A retrace strobe with table_swap_en high flips table_sel, independently of the page. table_base follows table_sel in the same way.
- R10: The swap enables have no effect without a retrace strobe. swap_done is 1 for exactly the cycle after a strobe that flipped at least one selection.
- R11: The mode input is taken only when a word is accepted. Changing it while a word is being unpacked does not alter that word's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Colour mode: 0 true colour, 1 RGB565, 2 gray, 3 indexed |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Video memory word |
| in_ready | output | 1 | Block can take a word |
| out_valid | output | 1 | Pixel valid |
| out_rgb | output | 24 | Pixel, red in the top byte |
| out_ready | input | 1 | Downstream takes the pixel |
| lut_req | output | 1 | Colour table lookup request |
| lut_idx | output | LW | Colour table address |
| lut_ack | input | 1 | Lookup result present on lut_data |
| lut_data | input | 24 | Colour table entry |
| retrace | input | 1 | Vertical retrace strobe, one cycle |
| page_swap_en | input | 1 | Flip the video page at retrace |
| table_swap_en | input | 1 | Flip the colour table at retrace |
| page_base0 | input | AW | Video page 0 base |
| page_base1 | input | AW | Video page 1 base |
| table_base0 | input | LW | Colour table 0 offset |
| table_base1 | input | LW | Colour table 1 offset |
| page_base | output | AW | Active video page base |
| table_base | output | LW | Active colour table offset |
| page_sel | output | 1 | Active page number |
| table_sel | output | 1 | Active table number |
| swap_done | output | 1 | A swap took effect on the previous edge |

## Verification
The properties assume that the lookup responder raises lut_ack only while lut_req is high. They also assume retrace is a single-cycle pulse. The bench's responder acks only a pending request, and it strobes retrace in isolated cycles. The reference model works out expected table addresses from the table selection it tracks. For that reason the bench issues retrace strobes only in phases that carry no indexed-colour words, so no swap lands between a value's arrival and its lookup.

// File: rtl/pixel_formatter.sv
module pixel_formatter #(
  parameter int AW = 32,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [23:0]   out_rgb,
  input  logic          out_ready,
  output logic          lut_req,
  output logic [LW-1:0] lut_idx,
  input  logic          lut_ack,
  input  logic [23:0]   lut_data,
  input  logic          retrace,
  input  logic          page_swap_en,
  input  logic          table_swap_en,
  input  logic [AW-1:0] page_base0,
  input  logic [AW-1:0] page_base1,
  input  logic [LW-1:0] table_base0,
  input  logic [LW-1:0] table_base1,
  output logic [AW-1:0] page_base,
  output logic [LW-1:0] table_base,
  output logic          page_sel,
  output logic          table_sel,
  output logic          swap_done
);
  localparam logic [1:0] M_TRUE = 2'd0, M_565 = 2'd1, M_GRAY = 2'd2, M_IDX = 2'd3;

  logic        busy;
  logic [31:0] wbuf;
  logic [1:0]  wmode, cnt, last_cnt;
  logic [7:0]  pix8;
  logic [15:0] pix16;
  logic [23:0] fmt;
  logic        out_free, emit, issue, adv;

  assign in_ready   = !busy;
  assign out_free   = !out_valid || out_ready;
  assign pix8       = wbuf[{cnt, 3'b000} +: 8];
  assign pix16      = wbuf[{cnt[0], 4'b0000} +: 16];
  assign last_cnt   = (wmode == M_TRUE) ? 2'd0 : (wmode == M_565) ? 2'd1 : 2'd3;
  assign emit       = busy && out_free && (wmode != M_IDX);
  assign issue      = busy && out_free && (wmode == M_IDX) && !lut_req;
  assign adv        = emit || (lut_req && lut_ack);
  assign page_base  = page_sel  ? page_base1  : page_base0;
  assign table_base = table_sel ? table_base1 : table_base0;

  always_comb begin
    case (wmode)
      M_565:   fmt = {pix16[15:11], pix16[15:13], pix16[10:5], pix16[10:9],
                      pix16[4:0], pix16[4:2]};
      M_GRAY:  fmt = {pix8, pix8, pix8};
      default: fmt = wbuf[23:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      wbuf  <= '0;
      wmode <= M_TRUE;
      cnt   <= '0;
    end else if (in_valid && in_ready) begin
      busy  <= 1'b1;
      wbuf  <= in_data;
      wmode <= mode;
      cnt   <= '0;
    end else if (adv) begin
      if (cnt == last_cnt) busy <= 1'b0;
      else                 cnt  <= cnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_rgb   <= emit ? fmt : lut_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lut_req <= 1'b0;
      lut_idx <= '0;
    end else if (issue) begin
      lut_req <= 1'b1;
      lut_idx <= table_base + LW'(pix8);
    end else if (lut_ack) begin
      lut_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_sel  <= 1'b0;
      table_sel <= 1'b0;
      swap_done <= 1'b0;
    end else begin
      swap_done <= retrace && (page_swap_en || table_swap_en);
      if (retrace && page_swap_en)  page_sel  <= !page_sel;
      if (retrace && table_swap_en) table_sel <= !table_sel;
    end
  end
endmodule

// File: rtl/pixel_formatter_chk.sv
module pixel_formatter_chk #(
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [23:0]   out_rgb,
  input logic          out_ready,
  input logic          lut_req,
  input logic [LW-1:0] lut_idx,
  input logic          lut_ack,
  input logic          retrace,
  input logic          page_swap_en,
  input logic          table_swap_en,
  input logic          page_sel,
  input logic          table_sel,
  input logic          swap_done
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid && !lut_req && in_ready);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lut_req && !lut_ack |=> lut_req && $stable(lut_idx));

  p_ack_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lut_req && lut_ack |=> out_valid && !lut_req);

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb));

  p_page_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retrace && page_swap_en |=> page_sel != $past(page_sel));

  p_table_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retrace && table_swap_en |=> table_sel != $past(table_sel));

  p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !retrace |=> $stable(page_sel) && $stable(table_sel) && !swap_done);
endmodule

bind pixel_formatter pixel_formatter_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_rgb(out_rgb), .out_ready(out_ready),
  .lut_req(lut_req), .lut_idx(lut_idx), .lut_ack(lut_ack),
  .retrace(retrace), .page_swap_en(page_swap_en), .table_swap_en(table_swap_en),
  .page_sel(page_sel), .table_sel(table_sel), .swap_done(swap_done)
);

// File: tb/tb_pixel_formatter.sv
module tb_pixel_formatter;
  localparam int AW = 32, LW = 10;
  localparam logic [AW-1:0] PB0 = 32'h1000_0000, PB1 = 32'h2004_0000;
  localparam logic [LW-1:0] TB0 = 10'd0, TB1 = 10'd300;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic in_valid = 0, out_ready = 0, lut_ack = 0, retrace = 0;
  logic page_swap_en = 0, table_swap_en = 0;
  logic [31:0] in_data = 0;
  logic [23:0] lut_data = 0;
  logic in_ready, out_valid, lut_req, page_sel, table_sel, swap_done;
  logic [23:0] out_rgb;
  logic [LW-1:0] lut_idx, table_base;
  logic [AW-1:0] page_base;

  always #10 clk = ~clk;

  pixel_formatter #(.AW(AW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_rgb(out_rgb), .out_ready(out_ready),
    .lut_req(lut_req), .lut_idx(lut_idx), .lut_ack(lut_ack), .lut_data(lut_data),
    .retrace(retrace), .page_swap_en(page_swap_en), .table_swap_en(table_swap_en),
    .page_base0(PB0), .page_base1(PB1), .table_base0(TB0), .table_base1(TB1),
    .page_base(page_base), .table_base(table_base), .page_sel(page_sel),
    .table_sel(table_sel), .swap_done(swap_done));

  int checks = 0, errors = 0;
  bit run = 0, allow_strobe = 0, finished = 0;

  logic [31:0] sq_data[$];
  int          sq_mode[$];
  int          exp_pix[$];
  int          exp_idx[$];
  bit          cur_v = 0;
  int          cur_mode = 0;
  int          m_page = 0, m_table = 0, m_done = 0;
  bit          prev_stall = 0;
  logic [23:0] prev_rgb = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lut_fn(input int idx);
    return (idx * 40503 + 17) & 24'hFFFFFF;
  endfunction

  function automatic int widen565(input int p);
    int r, g, b;
    r = (p >> 11) & 31; g = (p >> 5) & 63; b = p & 31;
    return ((((r << 3) | (r >> 2)) << 16) | (((g << 2) | (g >> 4)) << 8) | ((b << 3) | (b >> 2)));
  endfunction

  task automatic expect_word(input logic [31:0] w, input int m);
    int tb;
    tb = (m_table != 0) ? int'(TB1) : int'(TB0);
    case (m)
      0: exp_pix.push_back(int'(w & 32'h00FF_FFFF));
      1: for (int k = 0; k < 2; k++) exp_pix.push_back(widen565(int'((w >> (16*k)) & 32'hFFFF)));
      2: for (int k = 0; k < 4; k++) begin
           int v;
           v = int'((w >> (8*k)) & 32'hFF);
           exp_pix.push_back(v * 65536 + v * 256 + v);
         end
      default: for (int k = 0; k < 4; k++) begin
           int ix;
           ix = (tb + int'((w >> (8*k)) & 32'hFF)) % (1 << LW);
           exp_idx.push_back(ix);
           exp_pix.push_back(lut_fn(ix));
         end
    endcase
  endtask

  always @(negedge clk) begin
    if (run && !finished) begin
      if (!cur_v && sq_data.size() > 0 && ($urandom % 4) != 0) begin
        cur_v = 1;
        in_data = sq_data.pop_front();
        cur_mode = sq_mode.pop_front();
      end
      in_valid = cur_v;
      mode = cur_v ? 2'(cur_mode) : 2'($urandom % 4);
      out_ready = ($urandom % 4) != 0;
      lut_ack = lut_req && ($urandom % 2);
      lut_data = lut_ack ? 24'(lut_fn(int'(lut_idx))) : 24'($urandom);
      retrace = allow_strobe && (($urandom % 8) == 0);
      page_swap_en = $urandom % 2;
      table_swap_en = $urandom % 2;
      #5;
      if (prev_stall) begin
        chk(out_valid, "R7 valid held", out_valid, 1);
        chk(out_rgb == prev_rgb, "R7 pixel held", out_rgb, prev_rgb);
      end
      prev_stall = out_valid && !out_ready;
      prev_rgb = out_rgb;
      if (out_valid && out_ready) begin
        if (exp_pix.size() == 0) chk(0, "R6 unexpected pixel", out_rgb, 0);
        else begin
          int e;
          e = exp_pix.pop_front();
          chk(int'(out_rgb) == e, "R2/R3/R4/R5 pixel value and R6 order", out_rgb, e);
        end
      end
      if (lut_req && lut_ack) begin
        if (exp_idx.size() == 0) chk(0, "R5 unexpected lookup", lut_idx, 0);
        else begin
          int e;
          e = exp_idx.pop_front();
          chk(int'(lut_idx) == e, "R5 lookup index", lut_idx, e);
        end
      end
      if (in_valid && in_ready) begin
        expect_word(in_data, cur_mode);
        cur_v = 0;
      end
      chk(int'(page_sel) == m_page, "R8 page_sel", page_sel, m_page);
      chk(page_base == (m_page != 0 ? PB1 : PB0), "R8 page_base", page_base, m_page != 0 ? PB1 : PB0);
      chk(int'(table_sel) == m_table, "R9 table_sel", table_sel, m_table);
      chk(table_base == (m_table != 0 ? TB1 : TB0), "R9 table_base", table_base, m_table != 0 ? TB1 : TB0);
      chk(int'(swap_done) == m_done, "R10 swap_done", swap_done, m_done);
      m_done = (retrace && (page_swap_en || table_swap_en)) ? 1 : 0;
      if (retrace && page_swap_en) m_page ^= 1;
      if (retrace && table_swap_en) m_table ^= 1;
    end
  end

  task automatic load(input int m, input int n);
    for (int i = 0; i < n; i++) begin
      sq_data.push_back($urandom);
      sq_mode.push_back(m < 0 ? int'($urandom % 4) : m);
    end
  endtask

  task automatic drain;
    while (sq_data.size() > 0 || cur_v || exp_pix.size() > 0 || exp_idx.size() > 0)
      @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk(!out_valid && !lut_req && in_ready, "R1 handshake idle in reset", {out_valid, lut_req, in_ready}, 3'b001);
    chk(!page_sel && !table_sel && !swap_done, "R1 selections cleared", {page_sel, table_sel, swap_done}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #5;
    chk(!out_valid && in_ready && !page_sel && !table_sel, "R1 state after reset",
        {out_valid, in_ready, page_sel, table_sel}, 4'b0100);
    run = 1;
    // R2 R3 R4 with strobes running; R11 via random mode while busy
    allow_strobe = 1; load(0, 12); drain();
    load(1, 12); drain();
    load(2, 12); drain();
    allow_strobe = 0;
    // R5 indexed colour, no strobes while lookups are pending
    load(3, 12); drain();
    load(-1, 40); drain();
    // R10 strobe-only phase, enables toggling every cycle
    allow_strobe = 1; repeat (200) @(negedge clk);
    allow_strobe = 0; repeat (4) @(negedge clk);
    load(3, 8); drain();
    allow_strobe = 1; load(0, 6); load(2, 6); drain();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end
endmodule